// File: doc/BRIEF.md
# UART Interrupt State Register Bank

This block keeps the interrupt bookkeeping for a serial port that raises four kinds of event: transmit level reached, receive level reached, transmitter drained and receive overrun. Each event arrives as a one-cycle pulse from detectors elsewhere in the port. The block turns each pulse into a sticky flag that stays set until software clears it. Each flag drives its own level interrupt line through a per-source mask.

Software reaches the bank through a 32-bit word-addressed register port with three locations. The flag register at offset 0x00 reads the sticky flags, and a write clears every flag written as one. The mask register at offset 0x04 is a plain read/write mask. The force register at offset 0x08 is write-only: a write ORs the value into the flags, which lets software raise any interrupt without its event. Reads are combinational on the address. Writes land on the next rising clock edge.

The bank has no sequencing of its own. Each source is an independent cell with two states, flag clear and flag set. An event or a force write moves a cell from clear to set. A clearing write moves it from set to clear, unless an event arrives in the same cycle. Reset returns every cell to clear.

Top module: `uirq_bank`

## Requirements
- R1: A synchronous active-low reset clears all flags and all mask bits, so every interrupt line is low and offsets 0x00 and 0x04 read zero.
- R2: An event pulse on source input bit i sets flag bit i, and the flag stays set after the pulse ends. The flag bit positions are 0 transmit level, 1 receive level, 2 transmitter drained and 3 receive overrun.
- R3: A write to offset 0x00 clears each flag whose data bit is 1 and leaves the other flags unchanged.
- R4: A write to offset 0x08 ORs data bits 3:0 into the flags.
- R5: A write to offset 0x04 loads data bits 3:0 into the mask, and a read of 0x04 returns the mask.
- R6: Interrupt line i is high exactly when flag i and mask bit i are both set.
- R7: A read of offset 0x08 returns zero.
- R8: When an event pulse and a clearing write hit the same flag in the same cycle, the flag ends set.
- R9: Bits 31:4 of every register read as zero, and writes to them have no effect.
- R10: A read of any offset other than 0x00, 0x04 and 0x08 returns zero, and a write there changes no flag or mask bit.
- R11: A register write takes effect at the next rising clock edge. Before that edge, the interrupt lines keep their old values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_i | input | 4 | One-cycle event pulses, one bit per source |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte address of the register port |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on reg_addr |
| irq_o | output | 4 | Level interrupt lines, one per source |

## Verification
The hardest corner is an event landing on a flag in the same cycle that software clears it. A design where the clear wins would drop that interrupt, and the flag would read back zero. Clearing writes use partial masks, so a design that clears every flag on any write, or that ignores the data, leaves the wrong flags set. Writes of all ones to the reserved bits, to the force register and to an unmapped offset check that no stray state appears and that the force register always reads zero. A change of mask alone must move the interrupt lines. The lines are also checked just before the write edge, so a design with a combinational write path would already show the new level there.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    // Number of interrupt sources and register width
    parameter int unsigned N_SRC  = 4;
    parameter int unsigned DATA_W = 32;
    parameter int unsigned ADDR_W = 8;

    // Word offsets of the three registers (byte offset >> 2)
    localparam logic [ADDR_W-3:0] WOFF_FLAG  = (ADDR_W-2)'(0);
    localparam logic [ADDR_W-3:0] WOFF_MASK  = (ADDR_W-2)'(1);
    localparam logic [ADDR_W-3:0] WOFF_FORCE = (ADDR_W-2)'(2);

    // Register selected by the current address
    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_FLAG  = 2'd1,
        SEL_MASK  = 2'd2,
        SEL_FORCE = 2'd3
    } reg_sel_e;

    // Decoded write strobes
    typedef struct packed {
        logic clr;
        logic msk;
        logic frc;
    } wr_strb_t;
endpackage

// File: rtl/uirq_decode.sv
module uirq_decode
    import uirq_pkg::*;
#(
    parameter int unsigned AW = ADDR_W
) (
    input  logic          we,
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel,
    output wr_strb_t      strb
);
    localparam int unsigned WAW = AW - 2;

    logic [WAW-1:0] word;

    assign word = addr[AW-1:2];

    always_comb begin
        sel = SEL_NONE;
        unique case (word)
            WOFF_FLAG:  sel = SEL_FLAG;
            WOFF_MASK:  sel = SEL_MASK;
            WOFF_FORCE: sel = SEL_FORCE;
            default:    sel = SEL_NONE;
        endcase
    end

    always_comb begin
        strb.clr = we && (sel == SEL_FLAG);
        strb.msk = we && (sel == SEL_MASK);
        strb.frc = we && (sel == SEL_FORCE);
    end
endmodule

// File: rtl/uirq_cell.sv
module uirq_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic ev,
    input  logic wbit,
    input  logic clr_we,
    input  logic msk_we,
    input  logic frc_we,
    output logic flag,
    output logic mask,
    output logic irq
);
    logic flag_d;
    logic mask_d;

    // Set terms are ORed after the clear, so an event beats a clear
    always_comb begin
        flag_d = (flag & ~(clr_we & wbit)) | ev | (frc_we & wbit);
        mask_d = msk_we ? wbit : mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
            mask <= 1'b0;
        end else begin
            flag <= flag_d;
            mask <= mask_d;
        end
    end

    assign irq = flag & mask;
endmodule

// File: rtl/uirq_rdmux.sv
module uirq_rdmux
    import uirq_pkg::*;
#(
    parameter int unsigned NS = N_SRC,
    parameter int unsigned DW = DATA_W
) (
    input  reg_sel_e        sel,
    input  logic [NS-1:0]   flags,
    input  logic [NS-1:0]   masks,
    output logic [DW-1:0]   rdata
);
    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_FLAG:  rdata[NS-1:0] = flags;
            SEL_MASK:  rdata[NS-1:0] = masks;
            SEL_FORCE: rdata = '0;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/uirq_bank.sv
module uirq_bank
    import uirq_pkg::*;
#(
    parameter int unsigned NS = N_SRC,
    parameter int unsigned DW = DATA_W,
    parameter int unsigned AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] ev_i,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic [NS-1:0] irq_o
);
    reg_sel_e      sel;
    wr_strb_t      strb;
    logic [NS-1:0] st_q;
    logic [NS-1:0] en_q;

    uirq_decode #(.AW(AW)) u_dec (
        .we   (reg_we),
        .addr (reg_addr),
        .sel  (sel),
        .strb (strb)
    );

    for (genvar i = 0; i < NS; i++) begin : g_src
        uirq_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .ev     (ev_i[i]),
            .wbit   (reg_wdata[i]),
            .clr_we (strb.clr),
            .msk_we (strb.msk),
            .frc_we (strb.frc),
            .flag   (st_q[i]),
            .mask   (en_q[i]),
            .irq    (irq_o[i])
        );
    end

    uirq_rdmux #(.NS(NS), .DW(DW)) u_rd (
        .sel   (sel),
        .flags (st_q),
        .masks (en_q),
        .rdata (reg_rdata)
    );
endmodule

// File: rtl/uirq_chk.sv
module uirq_chk #(
    parameter int unsigned NS = 4,
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NS-1:0] ev_i,
    input logic          reg_we,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic [NS-1:0] irq_o,
    input logic [NS-1:0] st_q
);
    logic [AW-3:0] word;
    assign word = reg_addr[AW-1:2];

    // R2 and R8: a pulsed source reads set on the following cycle
    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_i != '0) |=> ((st_q & $past(ev_i)) == $past(ev_i)));

    // R3: cleared bits are gone when no event competes
    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && word == (AW-2)'(0) && ev_i == '0)
        |=> ((st_q & $past(reg_wdata[NS-1:0])) == '0));

    // R4: forced bits read set afterwards
    p_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && word == (AW-2)'(2))
        |=> ((st_q & $past(reg_wdata[NS-1:0])) == $past(reg_wdata[NS-1:0])));

    // R6 and R11: lines only move after a write or an event
    p_irq_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && ev_i == '0) |=> $stable(irq_o));

    // R7: the force register reads as zero
    p_force_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (word == (AW-2)'(2)) |-> (reg_rdata == '0));

    // R9: reserved read bits stay zero
    p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DW-1:NS] == '0);
endmodule

bind uirq_bank uirq_chk #(.NS(NS), .DW(DW), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_i      (ev_i),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_o     (irq_o),
    .st_q      (st_q)
);

// File: tb/sim_uirq_bank.sv
`timescale 1ns/1ps
module sim_uirq_bank;
    localparam int NV = 12;
    localparam int VW = 89;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ev_i = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uirq_bank u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_i      (ev_i),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_o     (irq_o)
    );

    // {ev, we, waddr, wdata, raddr, expected rdata, expected irq}
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'h1, 1'b0, 8'h00, 32'h0000_0000, 8'h00, 32'h0000_0001, 4'h0},
        {4'h0, 1'b1, 8'h04, 32'hFFFF_FFFF, 8'h04, 32'h0000_000F, 4'h1},
        {4'h0, 1'b1, 8'h08, 32'h0000_000C, 8'h00, 32'h0000_000D, 4'hD},
        {4'h0, 1'b0, 8'h00, 32'h0000_0000, 8'h08, 32'h0000_0000, 4'hD},
        {4'h0, 1'b1, 8'h00, 32'h0000_0005, 8'h00, 32'h0000_0008, 4'h8},
        {4'h8, 1'b1, 8'h00, 32'h0000_0008, 8'h00, 32'h0000_0008, 4'h8},
        {4'h0, 1'b1, 8'h00, 32'hFFFF_FFF0, 8'h00, 32'h0000_0008, 4'h8},
        {4'h0, 1'b1, 8'h10, 32'h0000_000F, 8'h10, 32'h0000_0000, 4'h8},
        {4'h0, 1'b1, 8'h04, 32'h0000_0002, 8'h00, 32'h0000_0008, 4'h0},
        {4'h2, 1'b0, 8'h00, 32'h0000_0000, 8'h00, 32'h0000_000A, 4'h2},
        {4'h0, 1'b1, 8'h08, 32'hFFFF_FFF0, 8'h00, 32'h0000_000A, 4'h2},
        {4'h0, 1'b1, 8'h00, 32'h0000_000F, 8'h00, 32'h0000_0000, 4'h0}
    };
    localparam string VTAG [NV] = '{
        "R2", "R5", "R4", "R7", "R3", "R8", "R9", "R10", "R6", "R2", "R9", "R3"
    };

    task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic read_at(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        logic [31:0] rd;
        // R1: reset holds even with events and writes present
        ev_i = 4'hF;
        reg_we = 1'b1;
        reg_addr = 8'h08;
        reg_wdata = 32'hF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        ev_i = '0;
        reg_we = 1'b0;
        #1;
        check32("R1 irq", {28'h0, irq_o}, 32'h0);
        read_at(8'h00, rd);
        check32("R1 flags", rd, 32'h0);
        read_at(8'h04, rd);
        check32("R1 mask", rd, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ev_i      = VEC[i][88:85];
            reg_we    = VEC[i][84];
            reg_addr  = VEC[i][83:76];
            reg_wdata = VEC[i][75:44];
            @(posedge clk);
            @(negedge clk);
            ev_i   = '0;
            reg_we = 1'b0;
            read_at(VEC[i][43:36], rd);
            check32({VTAG[i], " rdata"}, rd, VEC[i][35:4]);
            check32({VTAG[i], " irq"}, {28'h0, irq_o}, {28'h0, VEC[i][3:0]});
        end

        // R11: a force write is not visible before its clock edge
        @(negedge clk);
        reg_we = 1'b1;
        reg_addr = 8'h08;
        reg_wdata = 32'hF;
        #1;
        check32("R11 before edge", {28'h0, irq_o}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
        #1;
        check32("R11 after edge", {28'h0, irq_o}, 32'h2);
        read_at(8'h00, rd);
        check32("R4 force all", rd, 32'hF);

        // R1: reset in the middle of operation
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        read_at(8'h00, rd);
        check32("R1 mid flags", rd, 32'h0);
        read_at(8'h04, rd);
        check32("R1 mid mask", rd, 32'h0);
        check32("R1 mid irq", {28'h0, irq_o}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule